// File: doc/BRIEF.md
# Streaming Profile Line-Fit Detrender

This block takes a one-dimensional intensity profile of a fixed number of signed pixels and removes its affine trend. It fits a least-squares straight line over pixel position and returns the residual of every pixel, together with the fitted slope and intercept. Typical use is ahead of a phase estimator. That estimator needs the tilt-free part of a fringe profile, and it has to keep up with a pixel stream without using a divider.

Pixels arrive one per cycle, and a start flag marks pixel 0. Each pixel is scaled up by a power of two on entry, so that the fixed-point fit keeps its fractional precision. The covariance pass needs the mean intensity first, so every profile is stored in one of two banks. The mean comes from the running sum times a rounded reciprocal of the pixel count. The slope comes from the covariance times a reciprocal of the position variance. Both are constants of elaboration, and the products are shifted down by 24 bits. While one bank is fitted and emitted, the next profile fills the other bank.

Top module: `detrend_lsq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_vld` is 0 and `in_ready` is 1.
- R2: A pixel is taken only in a cycle where `pix_vld` and `in_ready` are both 1. A taken pixel with `pix_sof`=1 becomes pixel 0 of a new profile and drops any partial profile. Pixels offered while `in_ready` is 0 are ignored.
- R3: Every pixel is multiplied by 2^SCALE (SCALE=4) on entry, and all outputs are in these scaled units. A flat profile of raw value v gives slope 0, intercept 16*v and all-zero residuals.
- R4: The mean intensity is floor(S*RM/2^24), where S is the sum of the scaled pixels and RM = floor((2^24 + NPIX/2)/NPIX).
- R5: With d_i = 2i-(NPIX-1) and C = sum of d_i*(p_i - mean), the slope is floor(C*RV/2^24), where RV = floor(2^25 / sum of d_i^2).
- R6: The intercept is floor((2*mean - slope*(NPIX-1))/2).
- R7: The residual of pixel i is floor((2*p_i - 2*mean - slope*d_i)/2).
- R8: Each profile is emitted as NPIX back-to-back `out_vld` cycles with `out_idx` running 0..NPIX-1 and `out_last` set only at NPIX-1. `coef_slope` and `coef_icpt` hold that profile's values for the whole burst.
- R9: A new profile may be loaded while the previous one is still being fitted or emitted. `in_ready` is 0 only while a complete profile waits for the fit engine.
- R10: All scaling-down is an arithmetic shift, so negative values round toward minus infinity.
- R11: Profiles are emitted in the order they were completed, and each one exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Pixel offered this cycle |
| pix_sof | input | 1 | Offered pixel is pixel 0 of a profile |
| pix_data | input | PIX_W (12) | Signed raw pixel intensity |
| in_ready | output | 1 | Block can take a pixel this cycle |
| out_vld | output | 1 | Residual on `out_pix` is valid |
| out_idx | output | IDX_W (4) | Position of the emitted residual |
| out_last | output | 1 | Last residual of the profile |
| out_pix | output | OUT_W (20) | Signed residual, scaled units |
| coef_slope | output | SL_W (18) | Signed fitted slope, scaled units per pixel |
| coef_icpt | output | IC_W (20) | Signed fitted intercept, scaled units |

## Verification
Two things can fall in the same cycle: loading pixels of a new profile into one bank, and fitting or emitting the previous profile from the other bank. The bench sends its table of profiles back to back. The second profile therefore streams in while the first is emitted, and a third waits with `in_ready` low. Both cases are recorded, and every residual and coefficient is compared against a reference computed from the formulas in R4 to R7. Garbage pixels are offered only in cycles where `in_ready` is low, and the check is that the profiles that follow come out unchanged and in order.

// File: rtl/detrend_pkg.sv
package detrend_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_MEAN,
    PH_COV,
    PH_SLOPE,
    PH_ICPT,
    PH_EMIT
  } phase_t;

  // doubled, centred position of pixel i: 2i-(n-1)
  function automatic int pos_dev(input int i, input int n);
    return 2 * i - (n - 1);
  endfunction

  // sum of squared doubled deviations, four times the position variance
  function automatic longint pos_var4(input int n);
    longint acc;
    acc = 0;
    for (int i = 0; i < n; i++) acc += longint'(pos_dev(i, n)) * longint'(pos_dev(i, n));
    return acc;
  endfunction

endpackage

// File: rtl/detrend_load.sv
module detrend_load #(
  parameter int NPIX  = 16,
  parameter int PIX_W = 12,
  parameter int SCALE = 4,
  parameter int SP_W  = 16,
  parameter int SUM_W = 21,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_vld,
  input  logic                    pix_sof,
  input  logic signed [PIX_W-1:0] pix_data,
  output logic                    in_ready,
  output logic                    hand_vld,
  output logic                    hand_bank,
  output logic signed [SUM_W-1:0] hand_sum,
  input  logic                    take,
  input  logic                    rd_bank,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [SP_W-1:0]  rd_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  logic signed [SP_W-1:0] mem [2][NPIX];

  logic                    wr_bank, wr_bank_n;
  logic                    held, held_n;
  logic [IDX_W-1:0]        cnt, cnt_n;
  logic signed [SUM_W-1:0] sum, sum_n;
  logic                    accept;
  logic [IDX_W-1:0]        widx;
  logic signed [SP_W-1:0]  p_scaled;

  assign accept   = pix_vld & ~held;
  assign widx     = pix_sof ? '0 : cnt;
  assign p_scaled = SP_W'(pix_data) <<< SCALE;

  always_comb begin
    wr_bank_n = wr_bank;
    held_n    = held;
    cnt_n     = cnt;
    sum_n     = sum;
    if (accept) begin
      sum_n = (widx == '0) ? SUM_W'(p_scaled) : sum + SUM_W'(p_scaled);
      if (widx == LAST_IDX) begin
        cnt_n  = '0;
        held_n = 1'b1;
      end else begin
        cnt_n = widx + IDX_W'(1);
      end
    end
    if (take) begin
      held_n    = 1'b0;
      wr_bank_n = ~wr_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      held    <= 1'b0;
      cnt     <= '0;
      sum     <= '0;
    end else begin
      wr_bank <= wr_bank_n;
      held    <= held_n;
      cnt     <= cnt_n;
      sum     <= sum_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_bank][widx] <= p_scaled;
  end

  assign rd_data   = mem[rd_bank][rd_idx];
  assign in_ready  = ~held;
  assign hand_vld  = held;
  assign hand_bank = wr_bank;
  assign hand_sum  = sum;

endmodule

// File: rtl/detrend_fit.sv
module detrend_fit
  import detrend_pkg::*;
#(
  parameter int     NPIX    = 16,
  parameter int     SP_W    = 16,
  parameter int     SUM_W   = 21,
  parameter int     IDX_W   = 4,
  parameter int     CV_W    = 32,
  parameter int     SL_W    = 18,
  parameter int     IC_W    = 20,
  parameter int     FRAC    = 24,
  parameter longint RECIP_M = 1048576,
  parameter longint RECIP_V = 24672
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    start_bank,
  input  logic signed [SUM_W-1:0] start_sum,
  input  logic signed [SP_W-1:0]  rd_data,
  output logic                    rd_bank,
  output logic [IDX_W-1:0]        rd_idx,
  output logic                    busy,
  output logic                    emit_en,
  output logic [IDX_W-1:0]        emit_idx,
  output logic signed [SP_W-1:0]  ybar,
  output logic signed [SL_W-1:0]  slope,
  output logic signed [IC_W-1:0]  icpt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  phase_t                  phase, phase_n;
  logic                    bank, bank_n;
  logic signed [SUM_W-1:0] sum, sum_n;
  logic [IDX_W-1:0]        idx, idx_n;
  logic signed [SP_W-1:0]  ybar_n;
  logic signed [CV_W-1:0]  covar, covar_n;
  logic signed [SL_W-1:0]  slope_n;
  logic signed [IC_W-1:0]  icpt_n;
  logic signed [63:0]      dpos, prod;

  always_comb begin
    phase_n = phase;
    bank_n  = bank;
    sum_n   = sum;
    idx_n   = idx;
    ybar_n  = ybar;
    covar_n = covar;
    slope_n = slope;
    icpt_n  = icpt;
    dpos    = 64'(pos_dev(int'(idx), NPIX));
    prod    = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        bank_n  = start_bank;
        sum_n   = start_sum;
        phase_n = PH_MEAN;
      end
      PH_MEAN: begin
        prod    = 64'(sum) * RECIP_M;
        ybar_n  = SP_W'(prod >>> FRAC);
        covar_n = '0;
        idx_n   = '0;
        phase_n = PH_COV;
      end
      PH_COV: begin
        prod    = dpos * (64'(rd_data) - 64'(ybar));
        covar_n = covar + CV_W'(prod);
        if (idx == LAST_IDX) begin
          idx_n   = '0;
          phase_n = PH_SLOPE;
        end else begin
          idx_n = idx + IDX_W'(1);
        end
      end
      PH_SLOPE: begin
        prod    = 64'(covar) * RECIP_V;
        slope_n = SL_W'(prod >>> FRAC);
        phase_n = PH_ICPT;
      end
      PH_ICPT: begin
        prod    = 2 * 64'(ybar) - 64'(slope) * 64'(NPIX - 1);
        icpt_n  = IC_W'(prod >>> 1);
        idx_n   = '0;
        phase_n = PH_EMIT;
      end
      PH_EMIT: begin
        if (idx == LAST_IDX) begin
          idx_n   = '0;
          phase_n = PH_IDLE;
        end else begin
          idx_n = idx + IDX_W'(1);
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      bank  <= 1'b0;
      sum   <= '0;
      idx   <= '0;
      ybar  <= '0;
      covar <= '0;
      slope <= '0;
      icpt  <= '0;
    end else begin
      phase <= phase_n;
      bank  <= bank_n;
      sum   <= sum_n;
      idx   <= idx_n;
      ybar  <= ybar_n;
      covar <= covar_n;
      slope <= slope_n;
      icpt  <= icpt_n;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign emit_en  = (phase == PH_EMIT);
  assign emit_idx = idx;
  assign rd_idx   = idx;
  assign rd_bank  = bank;

endmodule

// File: rtl/detrend_emit.sv
module detrend_emit
  import detrend_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int SP_W  = 16,
  parameter int IDX_W = 4,
  parameter int SL_W  = 18,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [SP_W-1:0]  pix,
  input  logic signed [SP_W-1:0]  ybar,
  input  logic signed [SL_W-1:0]  slope,
  output logic                    out_vld,
  output logic [IDX_W-1:0]        out_idx,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_pix
);

  logic                    vld_n, last_n;
  logic [IDX_W-1:0]        idx_n;
  logic signed [OUT_W-1:0] pix_n;
  logic signed [63:0]      resid2;

  always_comb begin
    resid2 = 2 * 64'(pix) - 2 * 64'(ybar)
           - 64'(slope) * 64'(pos_dev(int'(idx), NPIX));
    vld_n  = en;
    idx_n  = en ? idx : out_idx;
    last_n = en && (idx == IDX_W'(NPIX - 1));
    pix_n  = en ? OUT_W'(resid2 >>> 1) : out_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_last <= 1'b0;
      out_pix  <= '0;
    end else begin
      out_vld  <= vld_n;
      out_idx  <= idx_n;
      out_last <= last_n;
      out_pix  <= pix_n;
    end
  end

endmodule

// File: rtl/detrend_lsq.sv
module detrend_lsq
  import detrend_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int PIX_W = 12,
  parameter int SCALE = 4,
  parameter int FRAC  = 24,
  localparam int SP_W  = PIX_W + SCALE,
  localparam int IDX_W = $clog2(NPIX),
  localparam int SL_W  = SP_W + 2,
  localparam int IC_W  = SP_W + 4,
  localparam int OUT_W = SP_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_vld,
  input  logic                    pix_sof,
  input  logic signed [PIX_W-1:0] pix_data,
  output logic                    in_ready,
  output logic                    out_vld,
  output logic [IDX_W-1:0]        out_idx,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_pix,
  output logic signed [SL_W-1:0]  coef_slope,
  output logic signed [IC_W-1:0]  coef_icpt
);

  localparam int     SUM_W   = SP_W + IDX_W + 1;
  localparam int     CV_W    = SP_W + 2 * IDX_W + 4;
  localparam longint RECIP_M = ((longint'(1) <<< FRAC) + longint'(NPIX / 2)) / longint'(NPIX);
  localparam longint RECIP_V = (longint'(1) <<< (FRAC + 1)) / pos_var4(NPIX);

  logic                    hand_vld, hand_bank, take, busy;
  logic signed [SUM_W-1:0] hand_sum;
  logic                    rd_bank;
  logic [IDX_W-1:0]        rd_idx, emit_idx;
  logic signed [SP_W-1:0]  rd_data, ybar;
  logic                    emit_en;

  assign take = hand_vld & ~busy;

  detrend_load #(
    .NPIX(NPIX), .PIX_W(PIX_W), .SCALE(SCALE),
    .SP_W(SP_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
  ) u_load (
    .clk(clk), .rst_n(rst_n),
    .pix_vld(pix_vld), .pix_sof(pix_sof), .pix_data(pix_data),
    .in_ready(in_ready),
    .hand_vld(hand_vld), .hand_bank(hand_bank), .hand_sum(hand_sum),
    .take(take), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  detrend_fit #(
    .NPIX(NPIX), .SP_W(SP_W), .SUM_W(SUM_W), .IDX_W(IDX_W), .CV_W(CV_W),
    .SL_W(SL_W), .IC_W(IC_W), .FRAC(FRAC),
    .RECIP_M(RECIP_M), .RECIP_V(RECIP_V)
  ) u_fit (
    .clk(clk), .rst_n(rst_n),
    .start(take), .start_bank(hand_bank), .start_sum(hand_sum),
    .rd_data(rd_data), .rd_bank(rd_bank), .rd_idx(rd_idx),
    .busy(busy), .emit_en(emit_en), .emit_idx(emit_idx),
    .ybar(ybar), .slope(coef_slope), .icpt(coef_icpt)
  );

  detrend_emit #(
    .NPIX(NPIX), .SP_W(SP_W), .IDX_W(IDX_W), .SL_W(SL_W), .OUT_W(OUT_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .en(emit_en), .idx(emit_idx), .pix(rd_data),
    .ybar(ybar), .slope(coef_slope),
    .out_vld(out_vld), .out_idx(out_idx), .out_last(out_last), .out_pix(out_pix)
  );

endmodule

// File: rtl/detrend_lsq_chk.sv
module detrend_lsq_chk #(
  parameter int NPIX  = 16,
  parameter int IDX_W = 4,
  parameter int SL_W  = 18,
  parameter int IC_W  = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_vld,
  input logic [IDX_W-1:0]       out_idx,
  input logic                   out_last,
  input logic signed [SL_W-1:0] coef_slope,
  input logic signed [IC_W-1:0] coef_icpt
);

  // R8: residuals of one profile come on consecutive cycles in index order
  p_burst_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_last |=> out_vld && (out_idx == $past(out_idx) + IDX_W'(1)));

  // R8: a burst starts at index 0
  p_burst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> out_idx == '0);

  // R8: the last flag marks exactly the final index
  p_last_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_last == (out_idx == IDX_W'(NPIX - 1))));

  // R8: coefficients do not move inside a burst
  p_coef_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_last |=> $stable(coef_slope) && $stable(coef_icpt));

  // R11: one profile's burst never runs straight into the next
  p_burst_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_vld);

  // R8: last flag only with valid data
  p_last_needs_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_vld);

endmodule

bind detrend_lsq detrend_lsq_chk #(
  .NPIX(NPIX), .IDX_W(IDX_W), .SL_W(SL_W), .IC_W(IC_W)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .out_vld(out_vld), .out_idx(out_idx), .out_last(out_last),
  .coef_slope(coef_slope), .coef_icpt(coef_icpt)
);

// File: tb/test_detrend_lsq.sv
module test_detrend_lsq;

  localparam int NPIX  = 16;
  localparam int PIX_W = 12;
  localparam int SCALE = 4;
  localparam int FRAC  = 24;
  localparam int IDX_W = $clog2(NPIX);
  localparam int SL_W  = PIX_W + SCALE + 2;
  localparam int IC_W  = PIX_W + SCALE + 4;
  localparam int OUT_W = PIX_W + SCALE + 4;
  localparam int NSLOT = 32;
  localparam int NTAB  = 6;

  // stimulus table: base, ramp per pixel, wave amplitude
  localparam int TAB [NTAB][3] = '{
    '{   0,    0,  300},
    '{-500,   40,  200},
    '{ 800,  -60,  500},
    '{-1000,   5,  900},
    '{1500, -100,   50},
    '{   0,   37,    0}
  };

  logic                    clk, rst_n;
  logic                    pix_vld, pix_sof;
  logic signed [PIX_W-1:0] pix_data;
  logic                    in_ready, out_vld, out_last;
  logic [IDX_W-1:0]        out_idx;
  logic signed [OUT_W-1:0] out_pix;
  logic signed [SL_W-1:0]  coef_slope;
  logic signed [IC_W-1:0]  coef_icpt;

  detrend_lsq #(.NPIX(NPIX), .PIX_W(PIX_W), .SCALE(SCALE), .FRAC(FRAC)) i_detrend_lsq (
    .clk(clk), .rst_n(rst_n),
    .pix_vld(pix_vld), .pix_sof(pix_sof), .pix_data(pix_data),
    .in_ready(in_ready),
    .out_vld(out_vld), .out_idx(out_idx), .out_last(out_last), .out_pix(out_pix),
    .coef_slope(coef_slope), .coef_icpt(coef_icpt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  n_chk, n_bad;
  bit  finished;
  int  tx_prof, rx_prof, rx_j;
  bit  saw_overlap, saw_block;
  longint exp_pix [NSLOT][NPIX];
  longint exp_sl  [NSLOT];
  longint exp_ic  [NSLOT];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference from R3..R7 and R10
  task automatic model(input int raw [NPIX], input int slot);
    longint p [NPIX];
    longint s, rm, rv, v4, ybar, cv, sl, d;
    s  = 0;
    v4 = 0;
    for (int i = 0; i < NPIX; i++) begin
      p[i] = longint'(raw[i]) * (longint'(1) <<< SCALE);
      s += p[i];
      d  = 2 * i - (NPIX - 1);
      v4 += d * d;
    end
    rm   = ((longint'(1) <<< FRAC) + NPIX / 2) / NPIX;
    rv   = (longint'(1) <<< (FRAC + 1)) / v4;
    ybar = (s * rm) >>> FRAC;
    cv   = 0;
    for (int i = 0; i < NPIX; i++) cv += longint'(2 * i - (NPIX - 1)) * (p[i] - ybar);
    sl   = (cv * rv) >>> FRAC;
    exp_sl[slot] = sl;
    exp_ic[slot] = (2 * ybar - sl * (NPIX - 1)) >>> 1;
    for (int i = 0; i < NPIX; i++)
      exp_pix[slot][i] = (2 * p[i] - 2 * ybar - sl * longint'(2 * i - (NPIX - 1))) >>> 1;
  endtask

  task automatic send_px(input int v, input bit sof);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    pix_vld  = 1'b1;
    pix_sof  = sof;
    pix_data = PIX_W'(v);
    @(posedge clk);
    #1;
    pix_vld = 1'b0;
    pix_sof = 1'b0;
  endtask

  task automatic send_profile(input int raw [NPIX]);
    model(raw, tx_prof);
    for (int i = 0; i < NPIX; i++) send_px(raw[i], i == 0);
    tx_prof++;
  endtask

  function automatic int clamp12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  // output monitor, sampled one time unit after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && out_vld) begin
      if (out_vld && pix_vld && in_ready) saw_overlap = 1'b1;
      if (!in_ready) saw_block = 1'b1;
      chk(out_idx == IDX_W'(rx_j), "R8 output index order", longint'(out_idx), longint'(rx_j));
      chk(out_last == (rx_j == NPIX - 1), "R8 last flag", longint'(out_last), longint'(rx_j == NPIX - 1));
      chk(longint'(out_pix) == exp_pix[rx_prof][rx_j], "R7 R4 R10 R2 residual",
          longint'(out_pix), exp_pix[rx_prof][rx_j]);
      if (rx_j == 0) begin
        chk(longint'(coef_slope) == exp_sl[rx_prof], "R5 R11 slope", longint'(coef_slope), exp_sl[rx_prof]);
        chk(longint'(coef_icpt) == exp_ic[rx_prof], "R6 R3 intercept", longint'(coef_icpt), exp_ic[rx_prof]);
      end
      if (rx_j == NPIX - 1) begin
        rx_j = 0;
        rx_prof++;
      end else begin
        rx_j++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", rx_prof, tx_prof);
    summary();
  end

  initial begin
    int raw [NPIX];
    n_chk = 0; n_bad = 0; finished = 1'b0;
    tx_prof = 0; rx_prof = 0; rx_j = 0;
    saw_overlap = 1'b0; saw_block = 1'b0;
    pix_vld = 1'b0; pix_sof = 1'b0; pix_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld in reset", longint'(out_vld), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld after reset", longint'(out_vld), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // table of profiles, sent back to back (R9 overlap)
    for (int t = 0; t < NTAB; t++) begin
      for (int j = 0; j < NPIX; j++) begin
        int w;
        w = (j % 4 == 1) ? 1 : ((j % 4 == 3) ? -1 : 0);
        raw[j] = clamp12(TAB[t][0] + TAB[t][1] * j + TAB[t][2] * w);
      end
      send_profile(raw);
    end

    // R2: pixels offered only while in_ready is low must be ignored
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      pix_vld  = !in_ready;
      pix_sof  = 1'b1;
      pix_data = PIX_W'(-1);
      @(posedge clk);
      #1;
      pix_vld = 1'b0;
      pix_sof = 1'b0;
    end

    // R2: partial profile then restart with a new start flag
    for (int j = 0; j < 5; j++) send_px(1000 - 300 * j, j == 0);
    for (int j = 0; j < NPIX; j++) raw[j] = (j % 2 == 0) ? 2047 : -2048;
    send_profile(raw);

    // R10: extreme negative and positive flats, then odd negative ramp
    for (int j = 0; j < NPIX; j++) raw[j] = -2048;
    send_profile(raw);
    for (int j = 0; j < NPIX; j++) raw[j] = -3 * j - 1 + ((j % 3 == 0) ? 7 : 0);
    send_profile(raw);
    for (int j = 0; j < NPIX; j++) raw[j] = 2047;
    send_profile(raw);

    // R3: flat profile, last so its coefficients stay on the outputs
    for (int j = 0; j < NPIX; j++) raw[j] = 100;
    send_profile(raw);

    while (rx_prof < tx_prof) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rx_prof == tx_prof, "R11 profile count", longint'(rx_prof), longint'(tx_prof));
    chk(longint'(coef_slope) == 0, "R3 flat slope", longint'(coef_slope), 0);
    chk(longint'(coef_icpt) == 1600, "R3 flat intercept", longint'(coef_icpt), 1600);
    chk(out_vld == 1'b0, "R8 idle after bursts", longint'(out_vld), 0);
    chk(saw_overlap, "R9 load during emission", longint'(saw_overlap), 1);
    chk(saw_block, "R9 in_ready low while profile waits", longint'(saw_block), 1);
    chk(in_ready == 1'b1, "R9 ready when nothing waits", longint'(in_ready), 1);
    summary();
  end

endmodule